// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block drives a two-backplane liquid-crystal panel: 23 segment lines and 2 common lines, multiplexed two ways at half bias. Each output is a 2-bit level code (low, mid, high), and an analog stage outside the block turns the code into a voltage. A prescaler derives the frame timing from the system clock. A frame has four equal phases. In each phase one common is selected and driven to a full level, and the other rests at mid. Across one frame each common is selected once at high and once at low, so the net DC across every pixel is zero.

The host loads the 46 pixel latches seven bits at a time, one digit slot per write. A raw write stores the seven data bits unchanged. A decode write converts a 4-bit value into a seven-segment glyph and stores that glyph. Reset clears every latch, so the panel is blank while the commons keep their normal waveform. Standby forces every output low. A build-time mask turns chosen segment lines into static general-purpose outputs.

Top module: `lcd_mux_drv`

## Requirements
- R1: Level codes are LOW=2'b00, MID=2'b01 and HIGH=2'b10, and code 2'b11 never appears. Common c is `com_lvl[2c+1:2c]`. Outside standby the phases repeat in the order: common 0 HIGH, then common 1 HIGH, then common 0 LOW, then common 1 LOW. The common that is not selected sits at MID.
- R2: Every phase lasts exactly PHASE_DIV = CLK_HZ/(4*FRAME_HZ) clock cycles.
- R3: Pixel p belongs to segment line p>>1 and common p&1. A non-mask segment line shows the selected common's level when the pixel on that common is unlit, and the opposite full level (HIGH against LOW, LOW against HIGH) when it is lit. Such a line is never MID outside standby.
- R4: A raw write (`wr_decode`=0) stores `wr_data[j]` into pixel `wr_addr*7+j` for j=0..6. The new value shows on the outputs from the cycle after the write edge.
- R5: A decode write (`wr_decode`=1) stores the glyph of `wr_data[3:0]` in the same place, with segment a..g at bit j=0..6. The glyphs, from 0 to F, are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. Bits `wr_data[6:4]` are ignored.
- R6: Pixel indices at or above 46 are dropped. A write with `wr_addr` of 7 or more changes no pixel.
- R7: After reset every pixel is unlit and the phase counter starts at phase 0 (common 0 HIGH, common 1 MID).
- R8: While `stby`=1, every segment and common output is LOW. Pixel latches keep their contents and still accept writes. When standby ends, the phase sequence restarts at phase 0.
- R9: A segment line whose bit is set in GPO_MASK is static. It shows HIGH when either of its two pixels is lit and LOW otherwise, and LOW in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stby | input | 1 | Standby: all outputs low, timing held at phase 0 |
| wr_en | input | 1 | Write strobe for one digit slot |
| wr_decode | input | 1 | 0 = raw write, 1 = seven-segment decode write |
| wr_addr | input | AW (3) | Digit slot; pixels wr_addr*7 .. wr_addr*7+6 |
| wr_data | input | 7 | Raw bits, or hex value in bits 3:0 |
| seg_lvl | output | 2*NSEG (46) | Level code per segment line, line s at bits 2s+1:2s |
| com_lvl | output | 4 | Level code per common line, common c at bits 2c+1:2c |

## Verification
The bench sets CLK_HZ=400 and FRAME_HZ=10, which gives a phase of ten cycles. With these values the bench can watch whole frames and time each phase exactly instead of waiting 11250 cycles per phase. It sets GPO_MASK=23'h000401, so segment lines 0 and 10 become static outputs and the rest stay multiplexed. This puts both output kinds in one build, and the mask logic can be checked against the multiplexed lines next to it. The bench recovers the pixel image from the port waveforms by comparing each line with the selected common. Slot 6 is only partly filled, so it shows clipping at the end of the pixel range.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  // Segment a..g at bit 0..6
  function automatic logic [6:0] digit_glyph(input logic [3:0] v);
    logic [6:0] g;
    case (v)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lcd_mux_timebase.sv
module lcd_mux_timebase #(
  parameter int unsigned PHASE_DIV = 11250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby,
  output logic [1:0] phase
);

  localparam int unsigned CW = $clog2(PHASE_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    phase_q, phase_d;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (stby) begin
      cnt_d   = '0;
      phase_d = 2'd0;
    end else if (tick) begin
      cnt_d   = '0;
      phase_d = phase_q + 2'd1;
    end else begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 2'd0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/lcd_mux_store.sv
module lcd_mux_store
  import lcd_mux_pkg::*;
#(
  parameter int unsigned NPIX = 46,
  parameter int unsigned AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_decode,
  input  logic [AW-1:0]   wr_addr,
  input  logic [6:0]      wr_data,
  output logic [NPIX-1:0] pix
);

  logic [6:0]      pat;
  logic [NPIX-1:0] pix_q, pix_d, pix_we;

  assign pat = wr_decode ? digit_glyph(wr_data[3:0]) : wr_data;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    localparam int unsigned DSLOT = p / 7;
    localparam int unsigned DBIT  = p % 7;

    assign pix_we[p] = wr_en && (wr_addr == AW'(DSLOT));

    always_comb begin
      pix_d[p] = pix_q[p];
      if (pix_we[p]) pix_d[p] = pat[DBIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_q[p] <= 1'b0;
      else        pix_q[p] <= pix_d[p];
    end
  end

  assign pix = pix_q;

endmodule

// File: rtl/lcd_mux_wave.sv
module lcd_mux_wave
  import lcd_mux_pkg::*;
#(
  parameter int unsigned       NSEG     = 23,
  parameter logic [NSEG-1:0]   GPO_MASK = '0
) (
  input  logic [1:0]        phase,
  input  logic              stby,
  input  logic [2*NSEG-1:0] pix,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic [3:0]        com_lvl
);

  lvl_e sel_lvl, anti_lvl;

  // phase[0] picks the selected common, phase[1] its polarity
  always_comb begin
    sel_lvl  = phase[1] ? LVL_LOW  : LVL_HIGH;
    anti_lvl = phase[1] ? LVL_HIGH : LVL_LOW;
  end

  for (genvar c = 0; c < 2; c++) begin : g_com
    always_comb begin
      if (stby)                 com_lvl[2*c +: 2] = LVL_LOW;
      else if (phase[0] == c[0]) com_lvl[2*c +: 2] = sel_lvl;
      else                      com_lvl[2*c +: 2] = LVL_MID;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (GPO_MASK[s]) begin : g_static
      always_comb begin
        if (stby)                        seg_lvl[2*s +: 2] = LVL_LOW;
        else if (pix[2*s] | pix[2*s+1])  seg_lvl[2*s +: 2] = LVL_HIGH;
        else                             seg_lvl[2*s +: 2] = LVL_LOW;
      end
    end else begin : g_mux
      logic lit;
      assign lit = phase[0] ? pix[2*s+1] : pix[2*s];
      always_comb begin
        if (stby)     seg_lvl[2*s +: 2] = LVL_LOW;
        else if (lit) seg_lvl[2*s +: 2] = anti_lvl;
        else          seg_lvl[2*s +: 2] = sel_lvl;
      end
    end
  end

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv #(
  parameter int unsigned     NSEG     = 23,
  parameter int unsigned     CLK_HZ   = 4_500_000,
  parameter int unsigned     FRAME_HZ = 100,
  parameter logic [NSEG-1:0] GPO_MASK = '0,
  localparam int unsigned    NPIX     = 2 * NSEG,
  localparam int unsigned    NDIG     = (NPIX + 6) / 7,
  localparam int unsigned    AW       = $clog2(NDIG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby,
  input  logic              wr_en,
  input  logic              wr_decode,
  input  logic [AW-1:0]     wr_addr,
  input  logic [6:0]        wr_data,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic [3:0]        com_lvl
);

  localparam int unsigned PHASE_DIV = CLK_HZ / (4 * FRAME_HZ);

  logic            rst_meta_n, rst_sync_n;
  logic [1:0]      phase;
  logic [NPIX-1:0] pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  lcd_mux_timebase #(.PHASE_DIV(PHASE_DIV)) u_tb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .stby  (stby),
    .phase (phase)
  );

  lcd_mux_store #(.NPIX(NPIX), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_decode (wr_decode),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pix       (pix)
  );

  lcd_mux_wave #(.NSEG(NSEG), .GPO_MASK(GPO_MASK)) u_wave (
    .phase   (phase),
    .stby    (stby),
    .pix     (pix),
    .seg_lvl (seg_lvl),
    .com_lvl (com_lvl)
  );

endmodule

// File: rtl/lcd_mux_drv_chk.sv
module lcd_mux_drv_chk #(
  parameter int unsigned     NSEG     = 23,
  parameter logic [NSEG-1:0] GPO_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stby,
  input logic              wr_en,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic [3:0]        com_lvl
);

  logic [2*NSEG-1:0] gpo_wide;
  logic [1:0]        com_mid;
  logic              seg_mid_any, code3_any;

  always_comb begin
    seg_mid_any = 1'b0;
    code3_any   = (com_lvl[1:0] == 2'b11) || (com_lvl[3:2] == 2'b11);
    for (int s = 0; s < NSEG; s++) begin
      gpo_wide[2*s +: 2] = {2{GPO_MASK[s]}};
      if (!GPO_MASK[s] && seg_lvl[2*s +: 2] == 2'b01) seg_mid_any = 1'b1;
      if (seg_lvl[2*s +: 2] == 2'b11) code3_any = 1'b1;
    end
    com_mid = {com_lvl[3:2] == 2'b01, com_lvl[1:0] == 2'b01};
  end

  AST_STBY_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> (seg_lvl == '0 && com_lvl == '0)); // R8

  AST_ONE_COM_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |-> ($countones(com_mid) == 1)); // R1

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
    !code3_any); // R1

  AST_SEG_NEVER_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |-> !seg_mid_any); // R3

  AST_GPO_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && !$past(stby) && !$past(wr_en)) |->
      ((seg_lvl & gpo_wide) == ($past(seg_lvl) & gpo_wide))); // R9

endmodule

bind lcd_mux_drv lcd_mux_drv_chk #(.NSEG(NSEG), .GPO_MASK(GPO_MASK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stby    (stby),
  .wr_en   (wr_en),
  .seg_lvl (seg_lvl),
  .com_lvl (com_lvl)
);

// File: tb/sim_lcd_mux_drv.sv
`timescale 1ns/1ps
module sim_lcd_mux_drv;

  localparam int unsigned NSEG = 23;
  localparam int unsigned NPIX = 46;
  localparam logic [NSEG-1:0] MASK = 23'h000401;
  localparam int unsigned PDIV = 10;

  localparam logic [3:0] PH0 = 4'b0110;
  localparam logic [3:0] PH1 = 4'b1001;
  localparam logic [3:0] PH2 = 4'b0100;
  localparam logic [3:0] PH3 = 4'b0001;

  // {decode, addr[2:0], data[6:0], expected glyph[6:0]}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 3'd0, 7'h55, 7'h55},
    {1'b1, 3'd1, 7'h03, 7'h4F},
    {1'b1, 3'd2, 7'h0A, 7'h77},
    {1'b1, 3'd3, 7'h78, 7'h7F},
    {1'b0, 3'd4, 7'h21, 7'h21},
    {1'b1, 3'd5, 7'h0F, 7'h71},
    {1'b1, 3'd0, 7'h07, 7'h07},
    {1'b0, 3'd6, 7'h7F, 7'h7F}
  };

  logic clk = 1'b0;
  logic rst_n, stby, wr_en, wr_decode;
  logic [2:0] wr_addr;
  logic [6:0] wr_data;
  logic [2*NSEG-1:0] seg_lvl;
  logic [3:0] com_lvl;

  int checks = 0, fails = 0, cyc = 0;
  logic [NPIX-1:0] img_exp, img_got, pxmask;

  always #2 clk = ~clk;

  lcd_mux_drv #(.NSEG(NSEG), .CLK_HZ(400), .FRAME_HZ(10), .GPO_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .stby(stby), .wr_en(wr_en), .wr_decode(wr_decode),
    .wr_addr(wr_addr), .wr_data(wr_data), .seg_lvl(seg_lvl), .com_lvl(com_lvl)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit dec, input logic [2:0] a, input logic [6:0] d);
    logic [6:0] g;
    @(negedge clk);
    wr_en = 1'b1; wr_decode = dec; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    g = d;
    if (dec) begin
      case (d[3:0])
        4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
        4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
        4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
        4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
      endcase
    end
    for (int j = 0; j < 7; j++) begin
      int idx;
      idx = a * 7 + j;
      if (a < 7 && idx < NPIX) img_exp[idx] = g[j];
    end
  endtask

  task automatic wait_com(input logic [3:0] pat);
    @(negedge clk);
    while (com_lvl !== pat) @(negedge clk);
  endtask

  task automatic read_image();
    img_got = '0;
    wait_com(PH0);
    for (int s = 0; s < NSEG; s++)
      if (!MASK[s]) img_got[2*s] = (seg_lvl[2*s +: 2] == 2'b00);
    wait_com(PH1);
    for (int s = 0; s < NSEG; s++)
      if (!MASK[s]) img_got[2*s+1] = (seg_lvl[2*s +: 2] == 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; stby = 1'b0; wr_en = 1'b0; wr_decode = 1'b0;
    wr_addr = '0; wr_data = '0; img_exp = '0;
    for (int s = 0; s < NSEG; s++) begin
      pxmask[2*s]   = !MASK[s];
      pxmask[2*s+1] = !MASK[s];
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: phase 0 right after reset, blank image
    chk(com_lvl == PH0, "R7 start phase", com_lvl, PH0);
    read_image();
    chk(img_got == '0, "R7 blank", img_got, 0);

    // R1 and R2: sequence and phase length
    begin
      logic [3:0] seq [4];
      seq[0] = PH1; seq[1] = PH2; seq[2] = PH3; seq[3] = PH0;
      wait_com(PH0);
      for (int k = 0; k < 4; k++) begin
        int n;
        n = 0;
        while (com_lvl == (k == 0 ? PH0 : seq[k-1])) begin
          @(negedge clk);
          n++;
        end
        chk(com_lvl == seq[k], "R1 phase order", com_lvl, seq[k]);
        if (k > 0) chk(n == PDIV, "R2 phase length", n, PDIV);
      end
    end

    // Table walk: R4 raw, R5 decode, R6 clip
    for (int v = 0; v < 8; v++) begin
      string tag;
      wr(VEC[v][17], VEC[v][16:14], VEC[v][13:7]);
      tag = (v == 7) ? "R6 clip" : (VEC[v][17] ? "R5 decode" : "R4 raw");
      read_image();
      chk((img_got & pxmask) == (img_exp & pxmask), tag, img_got & pxmask, img_exp & pxmask);
    end

    // R3: segment line 1 holds pixel2=1 (common 0) and pixel3=0 (common 1)
    wait_com(PH0);
    chk(seg_lvl[3:2] == 2'b00, "R3 lit vs high", seg_lvl[3:2], 2'b00);
    wait_com(PH2);
    chk(seg_lvl[3:2] == 2'b10, "R3 lit vs low", seg_lvl[3:2], 2'b10);
    wait_com(PH3);
    chk(seg_lvl[3:2] == 2'b00, "R3 unlit follows low", seg_lvl[3:2], 2'b00);

    // R6: out-of-range slot changes nothing
    wr(1'b0, 3'd7, 7'h7F);
    read_image();
    chk((img_got & pxmask) == (img_exp & pxmask), "R6 addr 7 ignored", img_got, img_exp);

    // R9: static lines 0 and 10
    chk(seg_lvl[1:0] == 2'b10, "R9 line0 high", seg_lvl[1:0], 2'b10);
    chk(seg_lvl[21:20] == 2'b10, "R9 line10 high", seg_lvl[21:20], 2'b10);
    wr(1'b0, 3'd2, 7'h00);
    wr(1'b0, 3'd3, 7'h00);
    @(negedge clk);
    chk(seg_lvl[21:20] == 2'b00, "R9 line10 low", seg_lvl[21:20], 2'b00);
    chk(seg_lvl[1:0] == 2'b10, "R9 line0 kept", seg_lvl[1:0], 2'b10);

    // R8: standby
    wait_com(PH2);
    stby = 1'b1;
    @(negedge clk);
    chk(seg_lvl == '0 && com_lvl == '0, "R8 all low", {seg_lvl, com_lvl}, 0);
    wr(1'b0, 3'd1, 7'h7F);
    repeat (15) @(negedge clk);
    chk(seg_lvl == '0 && com_lvl == '0, "R8 still low", {seg_lvl, com_lvl}, 0);
    stby = 1'b0;
    @(negedge clk);
    chk(com_lvl == PH0, "R8 restart phase0", com_lvl, PH0);
    read_image();
    chk((img_got & pxmask) == (img_exp & pxmask), "R8 retained", img_got, img_exp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule